// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit buses, called A and B, through two independent lanes. The A-to-B lane carries traffic from bus A towards bus B, and the B-to-A lane carries traffic the other way. Each lane has four controls of its own: a capture clock, a storage register, a source select and an output enable. The select picks what the lane drives onto the far bus. That is either the live value on the near bus or the value held in the lane's register.

Each bus appears as a split pad interface: an input value, an output value and an output-enable. Tri-state resolution and any bus keeper sit outside the block. The lane registers capture on every rising edge of their own clock, whatever the selects and enables are doing. An active-low reset clears both registers at once. Each lane then releases its register from reset only on its own clock, a few edges after the reset input goes high.

Top module: `bus_link_xcvr`

## Requirements
- R1: While `rst_n` is low, both lane registers are zero with no clock edge needed. With stored source selected, `b_out` and `a_out` then read 8'h00.
- R2: Each rising edge of `cap_ab_clk` loads `a_in` into the A-to-B register, regardless of `sel_ab`, `sel_ba`, `oe_ab` and `oe_ba_n`.
- R3: Each rising edge of `cap_ba_clk` loads `b_in` into the B-to-A register, regardless of the selects and enables.
- R4: `b_oe` is active (1) exactly when `oe_ab` is 1. `a_oe` is active (1) exactly when `oe_ba_n` is 0. With `oe_ab`=0 and `oe_ba_n`=1, neither bus is driven (isolation).
- R5: With `sel_ab`=0 (live), `b_out` equals `a_in` combinationally. With `sel_ab`=1 (stored), `b_out` equals the A-to-B register.
- R6: With `sel_ba`=0 (live), `a_out` equals `b_in` combinationally. With `sel_ba`=1 (stored), `a_out` equals the B-to-A register.
- R7: After `rst_n` rises, each register stays zero through the first two rising edges of its own capture clock. It captures on the third edge.
- R8: A bus the block is driving can be captured. With B driven from live A and both clocks pulsed, both registers hold the A value.
- R9: With both enables active, both selects live and no external driver, the two buses reinforce each other and keep their last value.
- R10: If both capture clocks rise together while both lanes drive stored data onto both buses, the two registers exchange their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| cap_ab_clk | input | 1 | Capture clock of the A-to-B register (rising edge) |
| cap_ba_clk | input | 1 | Capture clock of the B-to-A register (rising edge) |
| sel_ab | input | 1 | B-side source: 0 live A data, 1 stored A data |
| sel_ba | input | 1 | A-side source: 0 live B data, 1 stored B data |
| oe_ab | input | 1 | Drive enable for bus B, active high |
| oe_ba_n | input | 1 | Drive enable for bus A, active low |
| a_in | input | 8 | Value present on bus A |
| a_out | output | 8 | Value the block offers to bus A |
| a_oe | output | 1 | Block drives bus A when 1 |
| b_in | input | 8 | Value present on bus B |
| b_out | output | 8 | Value the block offers to bus B |
| b_oe | output | 1 | Block drives bus B when 1 |

## Verification
Register capture and stored-data driving can fall on the same clock edge. When both lanes drive stored data and both clocks rise together, each register samples a bus that the other register is driving at that moment. The bench provokes this by loading two different values in isolation, then switching to stored transfer on both sides and pulsing both clocks in one cycle. It judges the result by reading both buses after they settle and expecting the two values to have swapped. A second overlap, capturing a bus the block itself drives, is judged the same way after the selects are switched to stored.

// File: rtl/bus_link_pkg.sv
package bus_link_pkg;

  // Default lane data width.
  localparam int BL_WIDTH = 8;

  // Lane indices used by the top-level generate loop.
  localparam int LANE_AB   = 0;
  localparam int LANE_BA   = 1;
  localparam int LANE_CNT  = 2;

  // Source chosen for the far-side bus.
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;

endpackage

// File: rtl/bl_rst_sync.sv
// Asserts asynchronously, releases on the local capture clock after STAGES edges.
module bl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rel
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_nxt;

  always_comb begin
    stage_nxt = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_nxt;
    end
  end

  assign rel = stage_q[STAGES-1];

endmodule

// File: rtl/bl_capture_reg.sv
// Lane storage: loads on every rising edge once the local reset is released.
module bl_capture_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rel,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;
  logic         cap_en;

  // Capture is unconditional: the enable is always on.
  assign cap_en = 1'b1;

  always_comb begin
    q_nxt = q;
    if (cap_en) begin
      q_nxt = d;
    end
  end

  always_ff @(posedge clk or negedge rel) begin
    if (!rel) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/bl_src_mux.sv
// Chooses live or stored data for the far-side bus.
module bl_src_mux
  import bus_link_pkg::*;
#(
  parameter int W = 8
) (
  input  src_sel_e     sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] y
);

  always_comb begin
    unique case (sel)
      SRC_STORED: y = stored;
      default:    y = live;
    endcase
  end

endmodule

// File: rtl/bl_lane.sv
// One direction: reset release, storage register and source select.
module bl_lane
  import bus_link_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] y,
  output logic         rel
);

  bl_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .rel   (rel)
  );

  bl_capture_reg #(.W(W)) u_reg (
    .clk (clk),
    .rel (rel),
    .d   (d),
    .q   (q)
  );

  bl_src_mux #(.W(W)) u_mux (
    .sel    (src_sel_e'(sel)),
    .live   (d),
    .stored (q),
    .y      (y)
  );

endmodule

// File: rtl/bus_link_xcvr.sv
module bus_link_xcvr
  import bus_link_pkg::*;
#(
  parameter int W           = BL_WIDTH,
  parameter int SYNC_STAGES = 2
) (
  input  logic         rst_n,
  input  logic         cap_ab_clk,
  input  logic         cap_ba_clk,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         oe_ab,
  input  logic         oe_ba_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);

  logic         lane_clk [LANE_CNT];
  logic         lane_sel [LANE_CNT];
  logic [W-1:0] lane_d   [LANE_CNT];
  logic [W-1:0] lane_q   [LANE_CNT];
  logic [W-1:0] lane_y   [LANE_CNT];
  logic         lane_rel [LANE_CNT];

  // Named views of lane state, also used by the bound checker.
  logic [W-1:0] ab_q;
  logic [W-1:0] ba_q;
  logic         ab_run;
  logic         ba_run;

  always_comb begin
    lane_clk[LANE_AB] = cap_ab_clk;
    lane_sel[LANE_AB] = sel_ab;
    lane_d[LANE_AB]   = a_in;
    lane_clk[LANE_BA] = cap_ba_clk;
    lane_sel[LANE_BA] = sel_ba;
    lane_d[LANE_BA]   = b_in;
  end

  for (genvar i = 0; i < LANE_CNT; i++) begin : g_lane
    bl_lane #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_lane (
      .clk   (lane_clk[i]),
      .rst_n (rst_n),
      .sel   (lane_sel[i]),
      .d     (lane_d[i]),
      .q     (lane_q[i]),
      .y     (lane_y[i]),
      .rel   (lane_rel[i])
    );
  end

  assign ab_q   = lane_q[LANE_AB];
  assign ba_q   = lane_q[LANE_BA];
  assign ab_run = lane_rel[LANE_AB];
  assign ba_run = lane_rel[LANE_BA];

  // The A-to-B lane feeds bus B; the B-to-A lane feeds bus A.
  assign b_out = lane_y[LANE_AB];
  assign a_out = lane_y[LANE_BA];
  assign b_oe  = oe_ab;
  assign a_oe  = ~oe_ba_n;

endmodule

// File: rtl/bus_link_xcvr_chk.sv
module bus_link_xcvr_chk #(
  parameter int W = 8
) (
  input logic         rst_n,
  input logic         cap_ab_clk,
  input logic         cap_ba_clk,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic [W-1:0] ab_q,
  input logic [W-1:0] ba_q,
  input logic         ab_run,
  input logic         ba_run
);

  // R2: the register holds what bus A carried at the previous edge.
  p_capture_ab_r2: assert property (@(posedge cap_ab_clk) disable iff (!ab_run)
    $past(ab_run) |-> ab_q == $past(a_in));

  // R3: same for the B-to-A lane.
  p_capture_ba_r3: assert property (@(posedge cap_ba_clk) disable iff (!ba_run)
    $past(ba_run) |-> ba_q == $past(b_in));

  // R5: live and stored sources on bus B.
  p_live_b_r5: assert property (@(posedge cap_ab_clk) disable iff (!rst_n)
    !sel_ab |-> b_out == a_in);
  p_stored_b_r5: assert property (@(posedge cap_ab_clk) disable iff (!rst_n)
    sel_ab |-> b_out == ab_q);

  // R6: live and stored sources on bus A.
  p_live_a_r6: assert property (@(posedge cap_ba_clk) disable iff (!rst_n)
    !sel_ba |-> a_out == b_in);
  p_stored_a_r6: assert property (@(posedge cap_ba_clk) disable iff (!rst_n)
    sel_ba |-> a_out == ba_q);

  // R7: registers stay clear until the local release.
  p_hold_clear_r7: assert property (@(posedge cap_ab_clk) disable iff (!rst_n)
    !ab_run |-> ab_q == '0);

endmodule

bind bus_link_xcvr bus_link_xcvr_chk #(.W(W)) u_chk (
  .rst_n      (rst_n),
  .cap_ab_clk (cap_ab_clk),
  .cap_ba_clk (cap_ba_clk),
  .sel_ab     (sel_ab),
  .sel_ba     (sel_ba),
  .a_in       (a_in),
  .b_in       (b_in),
  .a_out      (a_out),
  .b_out      (b_out),
  .ab_q       (ab_q),
  .ba_q       (ba_q),
  .ab_run     (ab_run),
  .ba_run     (ba_run)
);

// File: tb/bus_link_xcvr_test.sv
`timescale 1ns/1ps
module bus_link_xcvr_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cap_ab = 1'b0;
  logic       cap_ba = 1'b0;
  logic       sel_ab = 1'b0;
  logic       sel_ba = 1'b0;
  logic       oe_ab = 1'b0;
  logic       oe_ba_n = 1'b1;
  logic [7:0] a_bus = 8'h00;
  logic [7:0] b_bus = 8'h00;
  logic [7:0] a_out, b_out;
  logic       a_oe, b_oe;

  // External bus drivers
  logic       ext_a_en = 1'b0;
  logic       ext_b_en = 1'b0;
  logic [7:0] ext_a = 8'h00;
  logic [7:0] ext_b = 8'h00;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bus_link_xcvr uut (
    .rst_n      (rst_n),
    .cap_ab_clk (cap_ab),
    .cap_ba_clk (cap_ba),
    .sel_ab     (sel_ab),
    .sel_ba     (sel_ba),
    .oe_ab      (oe_ab),
    .oe_ba_n    (oe_ba_n),
    .a_in       (a_bus),
    .a_out      (a_out),
    .a_oe       (a_oe),
    .b_in       (b_bus),
    .b_out      (b_out),
    .b_oe       (b_oe)
  );

  // Bus resolution, one settling step per bench clock; an undriven bus keeps its value.
  always @(posedge clk) begin
    if (a_oe)          a_bus <= a_out;
    else if (ext_a_en) a_bus <= ext_a;
    if (b_oe)          b_bus <= b_out;
    else if (ext_b_en) b_bus <= ext_b;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic setup(input bit ea, input logic [7:0] va, input bit eb, input logic [7:0] vb,
                       input bit oab, input bit oba_n, input bit sab, input bit sba);
    @(negedge clk);
    ext_a_en = ea; ext_a = va; ext_b_en = eb; ext_b = vb;
    oe_ab = oab; oe_ba_n = oba_n; sel_ab = sab; sel_ba = sba;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input bit ab, input bit ba);
    @(negedge clk);
    cap_ab = ab; cap_ba = ba;
    @(negedge clk);
    cap_ab = 1'b0; cap_ba = 1'b0;
  endtask

  task automatic t_reset();
    setup(1, 8'hA5, 1, 8'h5B, 0, 1, 1, 1);
    settle();
    check("R1 reset b_out", b_out, 8'h00);
    check("R1 reset a_out", a_out, 8'h00);
    check("R4 isolation b_oe", {7'd0, b_oe}, 8'h00);
    check("R4 isolation a_oe", {7'd0, a_oe}, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    pulse(1, 1);
    pulse(1, 1);
    check("R7 held after two edges b", b_out, 8'h00);
    check("R7 held after two edges a", a_out, 8'h00);
    pulse(1, 1);
    #1;
    check("R7 R2 third edge captures A", b_out, 8'hA5);
    check("R7 R3 third edge captures B", a_out, 8'h5B);
  endtask

  task automatic t_realtime_ab();
    setup(1, 8'h3C, 0, 8'h00, 1, 1, 0, 0);
    settle();
    check("R5 live b_out", b_out, 8'h3C);
    check("R5 live bus B", b_bus, 8'h3C);
    check("R4 b_oe on", {7'd0, b_oe}, 8'h01);
    check("R4 a_oe off", {7'd0, a_oe}, 8'h00);
  endtask

  task automatic t_realtime_ba();
    setup(0, 8'h00, 1, 8'hC3, 0, 0, 0, 0);
    settle();
    check("R6 live a_out", a_out, 8'hC3);
    check("R6 live bus A", a_bus, 8'hC3);
    check("R4 a_oe on", {7'd0, a_oe}, 8'h01);
  endtask

  task automatic t_store_isolated();
    // capture with mixed selects and drivers off
    setup(1, 8'h11, 1, 8'h22, 0, 1, 0, 1);
    settle();
    pulse(1, 1);
    setup(1, 8'h99, 1, 8'h88, 0, 1, 1, 1);
    settle();
    check("R2 stored A regardless of sel/oe", b_out, 8'h11);
    check("R3 stored B regardless of sel/oe", a_out, 8'h22);
    check("R4 isolated bus A keeps external", a_bus, 8'h99);
    check("R4 isolated bus B keeps external", b_bus, 8'h88);
  endtask

  task automatic t_stored_transfer();
    setup(0, 8'h00, 0, 8'h00, 1, 0, 1, 1);
    settle();
    check("R5 stored onto bus B", b_bus, 8'h11);
    check("R6 stored onto bus A", a_bus, 8'h22);
    setup(0, 8'h00, 0, 8'h00, 0, 1, 1, 1);
  endtask

  task automatic t_both_from_a();
    setup(1, 8'h96, 0, 8'h00, 1, 1, 0, 0);
    settle();
    pulse(1, 1);
    setup(1, 8'h01, 0, 8'h00, 0, 1, 1, 1);
    settle();
    check("R8 A register from A", b_out, 8'h96);
    check("R8 B register from driven B", a_out, 8'h96);
  endtask

  task automatic t_swap();
    setup(1, 8'h0F, 1, 8'hF0, 0, 1, 0, 0);
    settle();
    pulse(1, 1);
    setup(0, 8'h00, 0, 8'h00, 1, 0, 1, 1);
    settle();
    check("R10 pre-swap bus A", a_bus, 8'hF0);
    check("R10 pre-swap bus B", b_bus, 8'h0F);
    pulse(1, 1);
    settle();
    check("R10 swapped bus A", a_bus, 8'h0F);
    check("R10 swapped bus B", b_bus, 8'hF0);
  endtask

  task automatic t_bus_hold();
    setup(1, 8'h5A, 0, 8'h00, 1, 1, 0, 0);
    settle();
    setup(0, 8'h00, 0, 8'h00, 1, 0, 0, 0);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R9 hold bus A", a_bus, 8'h5A);
    check("R9 hold bus B", b_bus, 8'h5A);
  endtask

  task automatic t_async_clear();
    setup(0, 8'h00, 0, 8'h00, 0, 1, 1, 1);
    settle();
    check("R1 pre-clear b_out", b_out, 8'hF0);
    #1 rst_n = 1'b0;
    #0.5;
    check("R1 async clear b_out", b_out, 8'h00);
    check("R1 async clear a_out", a_out, 8'h00);
    @(negedge clk) rst_n = 1'b1;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    t_reset();
    t_realtime_ab();
    t_realtime_ba();
    t_store_isolated();
    t_stored_transfer();
    t_both_from_a();
    t_swap();
    t_bus_hold();
    t_async_clear();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule